// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Pair

This unit runs a 32×32 multiply or a 32/32 divide over a number of clock cycles, in signed and unsigned forms. The result goes to two dedicated result registers, Hi and Lo, and not to the register file. A multiply leaves the upper half of its 64-bit product in Hi and the lower half in Lo. A divide leaves the quotient in Lo and the remainder in Hi. One start strobe begins an operation, and a function code selects which of the four operations runs.

Software gets the results back with two move requests: one returns Hi, the other returns Lo. While an operation is running, the unit holds `busy` high. A move request that arrives in that window is held inside the unit and answered as soon as the new result has been written, so a pipeline can use `busy` and the move handshake to stall a read until the data is ready. The datapath works on operand magnitudes and retires one bit per cycle: shift-and-add for the multiply, restoring subtraction for the divide. Signs are fixed up at the end.

Top module: `muldiv_unit`

## Requirements
- R1: A `start` pulse with `op_func` in {24, 25, 26, 27} while `busy` is low is accepted. `busy` is high from the next cycle for exactly WIDTH (32) consecutive cycles.
- R2: A `start` while `busy` is high, or with any other `op_func` value, is ignored. It does not raise `busy`, does not change the running operation and does not touch Hi or Lo.
- R3: Function code 24 is a signed multiply. Hi receives bits 63..32 and Lo receives bits 31..0 of the two's-complement product.
- R4: Function code 25 is an unsigned multiply. Both operands are treated as unsigned, and the 64-bit product is split into Hi and Lo as in R3.
- R5: Function code 26 is a signed divide. Lo receives the quotient, truncated toward zero. Hi receives the remainder, which takes the sign of the dividend. 0x80000000 / 0xFFFFFFFF gives Lo = 0x80000000 and Hi = 0.
- R6: Function code 27 is an unsigned divide. Lo receives the quotient and Hi receives the remainder of the two unsigned operands.
- R7: A divide whose divisor is zero keeps `busy` high for the same 32 cycles and leaves Hi and Lo unchanged.
- R8: A `mv_req` made while `busy` is low is answered one cycle later. `mv_valid` is high for one cycle, and `mv_data` holds Hi for `mv_func` = 16 or Lo for `mv_func` = 18. A `mv_req` with any other code produces no `mv_valid`.
- R9: A move request made while `busy` is high is held. It is answered with `mv_valid` in the second cycle after `busy` falls, and it carries the result just written.
- R10: After reset, `busy` and `mv_valid` are low and Hi and Lo both read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation |
| op_func | input | 6 | Operation function code (24..27) |
| opnd_a | input | WIDTH | First operand (multiplicand or dividend) |
| opnd_b | input | WIDTH | Second operand (multiplier or divisor) |
| mv_req | input | 1 | Move request strobe |
| mv_func | input | 6 | Move function code (16 = Hi, 18 = Lo) |
| busy | output | 1 | An operation is in progress |
| mv_valid | output | 1 | `mv_data` holds the answer to a move request |
| mv_data | output | WIDTH | Hi or Lo value returned by a move |

## Verification
The bench builds the unit with the default WIDTH of 32, so every operand value is legal. This brings the real corner values within reach: the most negative number, all-ones, and signed results that wrap. Directed cases cover products of the most negative value with itself, the wrapping signed divide, mixed-sign truncation and a zero divisor. Random operations are mixed in among them, and each result is compared with 64-bit arithmetic in the bench. Extra cases cover a second start during an operation, a move request held across completion, and unknown function codes.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_MUL_S = 6'd24;
  localparam logic [FUNC_W-1:0] FN_MUL_U = 6'd25;
  localparam logic [FUNC_W-1:0] FN_DIV_S = 6'd26;
  localparam logic [FUNC_W-1:0] FN_DIV_U = 6'd27;
  localparam logic [FUNC_W-1:0] FN_GET_HI = 6'd16;
  localparam logic [FUNC_W-1:0] FN_GET_LO = 6'd18;

  typedef enum logic [1:0] {
    K_MUL_S = 2'd0,
    K_MUL_U = 2'd1,
    K_DIV_S = 2'd2,
    K_DIV_U = 2'd3
  } op_kind_e;

  function automatic logic is_arith_code(input logic [FUNC_W-1:0] f);
    return (f == FN_MUL_S) || (f == FN_MUL_U) || (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction

  function automatic op_kind_e code_to_kind(input logic [FUNC_W-1:0] f);
    return op_kind_e'(f[1:0]);
  endfunction
endpackage

// File: rtl/muldiv_mul_step.sv
`timescale 1ns/1ps
module muldiv_mul_step #(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0]   mcand_i,
  output logic [2*WIDTH-1:0] acc_o
);
  logic [WIDTH:0] partial;

  always_comb begin
    partial = {1'b0, acc_i[2*WIDTH-1:WIDTH]} + (acc_i[0] ? {1'b0, mcand_i} : '0);
    acc_o   = {partial, acc_i[WIDTH-1:1]};
  end
endmodule

// File: rtl/muldiv_div_step.sv
`timescale 1ns/1ps
module muldiv_div_step #(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0]   dvsr_i,
  output logic [2*WIDTH-1:0] acc_o
);
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] trial;

  always_comb begin
    shifted = {acc_i[2*WIDTH-1:WIDTH], acc_i[WIDTH-1]};
    trial   = shifted - {1'b0, dvsr_i};
    if (trial[WIDTH]) begin
      acc_o = {shifted[WIDTH-1:0], acc_i[WIDTH-2:0], 1'b0};
    end else begin
      acc_o = {trial[WIDTH-1:0], acc_i[WIDTH-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [FUNC_W-1:0]    op_func,
  input  logic [WIDTH-1:0]     opnd_a,
  input  logic [WIDTH-1:0]     opnd_b,
  input  logic                 mv_req,
  input  logic [FUNC_W-1:0]    mv_func,
  output logic                 busy,
  output logic                 mv_valid,
  output logic [WIDTH-1:0]     mv_data
);
  localparam int ACC_W = 2 * WIDTH;
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  // operation state
  logic                 busy_q;
  logic [CNT_W-1:0]     step_q;
  logic                 is_div_q;
  logic                 neg_main_q;
  logic                 neg_rem_q;
  logic                 zero_dvsr_q;
  logic [WIDTH-1:0]     m_q;
  logic [ACC_W-1:0]     acc_q;
  logic [WIDTH-1:0]     hi_q;
  logic [WIDTH-1:0]     lo_q;

  // move state
  logic                 pend_q;
  logic                 pend_hi_q;
  logic                 mv_valid_q;
  logic [WIDTH-1:0]     mv_data_q;

  // launch decode
  op_kind_e             kind;
  logic                 accept;
  logic                 k_signed;
  logic                 k_div;
  logic                 a_neg;
  logic                 b_neg;
  logic [WIDTH-1:0]     a_mag;
  logic [WIDTH-1:0]     b_mag;

  always_comb begin
    kind     = code_to_kind(op_func);
    accept   = start && !busy_q && is_arith_code(op_func);
    k_signed = (kind == K_MUL_S) || (kind == K_DIV_S);
    k_div    = (kind == K_DIV_S) || (kind == K_DIV_U);
    a_neg    = k_signed && opnd_a[WIDTH-1];
    b_neg    = k_signed && opnd_b[WIDTH-1];
    a_mag    = a_neg ? -opnd_a : opnd_a;
    b_mag    = b_neg ? -opnd_b : opnd_b;
  end

  // one iteration of each datapath, selected by the running kind
  logic [ACC_W-1:0] mul_nxt;
  logic [ACC_W-1:0] div_nxt;
  logic [ACC_W-1:0] acc_nxt;

  muldiv_mul_step #(.WIDTH(WIDTH)) u_mul_step (
    .acc_i   (acc_q),
    .mcand_i (m_q),
    .acc_o   (mul_nxt)
  );

  muldiv_div_step #(.WIDTH(WIDTH)) u_div_step (
    .acc_i  (acc_q),
    .dvsr_i (m_q),
    .acc_o  (div_nxt)
  );

  assign acc_nxt = is_div_q ? div_nxt : mul_nxt;

  // final sign correction
  logic [ACC_W-1:0] prod_fix;
  logic [WIDTH-1:0] quo_fix;
  logic [WIDTH-1:0] rem_fix;
  logic [WIDTH-1:0] hi_new;
  logic [WIDTH-1:0] lo_new;

  always_comb begin
    prod_fix = neg_main_q ? -acc_nxt : acc_nxt;
    quo_fix  = neg_main_q ? -acc_nxt[WIDTH-1:0] : acc_nxt[WIDTH-1:0];
    rem_fix  = neg_rem_q ? -acc_nxt[ACC_W-1:WIDTH] : acc_nxt[ACC_W-1:WIDTH];
    if (is_div_q) begin
      hi_new = rem_fix;
      lo_new = quo_fix;
    end else begin
      hi_new = prod_fix[ACC_W-1:WIDTH];
      lo_new = prod_fix[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      step_q      <= '0;
      is_div_q    <= 1'b0;
      neg_main_q  <= 1'b0;
      neg_rem_q   <= 1'b0;
      zero_dvsr_q <= 1'b0;
      m_q         <= '0;
      acc_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
    end else if (accept) begin
      busy_q      <= 1'b1;
      step_q      <= '0;
      is_div_q    <= k_div;
      neg_main_q  <= a_neg ^ b_neg;
      neg_rem_q   <= a_neg;
      zero_dvsr_q <= k_div && (opnd_b == '0);
      m_q         <= k_div ? b_mag : a_mag;
      acc_q       <= {{WIDTH{1'b0}}, (k_div ? a_mag : b_mag)};
    end else if (busy_q) begin
      acc_q  <= acc_nxt;
      step_q <= step_q + 1'b1;
      if (step_q == LAST_STEP) begin
        busy_q <= 1'b0;
        if (!zero_dvsr_q) begin
          hi_q <= hi_new;
          lo_q <= lo_new;
        end
      end
    end
  end

  // move handling: answer at once when idle, otherwise hold one request
  logic mv_is_hi;
  logic mv_known;

  always_comb begin
    mv_is_hi = (mv_func == FN_GET_HI);
    mv_known = mv_is_hi || (mv_func == FN_GET_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_hi_q  <= 1'b0;
      mv_valid_q <= 1'b0;
      mv_data_q  <= '0;
    end else begin
      mv_valid_q <= 1'b0;
      if (pend_q) begin
        if (!busy_q) begin
          pend_q     <= 1'b0;
          mv_valid_q <= 1'b1;
          mv_data_q  <= pend_hi_q ? hi_q : lo_q;
        end
      end else if (mv_req && mv_known) begin
        if (busy_q) begin
          pend_q    <= 1'b1;
          pend_hi_q <= mv_is_hi;
        end else begin
          mv_valid_q <= 1'b1;
          mv_data_q  <= mv_is_hi ? hi_q : lo_q;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mv_valid = mv_valid_q;
  assign mv_data  = mv_data_q;
endmodule

// File: rtl/muldiv_unit_checker.sv
`timescale 1ns/1ps
module muldiv_unit_checker
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [FUNC_W-1:0] op_func,
  input logic              mv_req,
  input logic [FUNC_W-1:0] mv_func,
  input logic              busy,
  input logic              mv_valid
);
  localparam int RUN_W = $clog2(WIDTH) + 2;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R1: accepted start raises busy
  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && is_arith_code(op_func)) |=> busy);

  // R1: busy lasts exactly WIDTH cycles
  p_busy_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == RUN_W'(WIDTH)));

  p_busy_max_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < RUN_W'(WIDTH)));

  // R2: an unknown code does not launch
  p_bad_code_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !is_arith_code(op_func)) |=> !busy);

  // R8: idle move is answered next cycle
  p_mv_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (mv_req && !busy && (mv_func == FN_GET_HI || mv_func == FN_GET_LO)) |=> mv_valid);

  // R8/R9: an answer is only given after an idle cycle
  p_mv_after_idle_r9: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> $past(!busy));
endmodule

bind muldiv_unit muldiv_unit_checker #(.WIDTH(WIDTH)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .op_func  (op_func),
  .mv_req   (mv_req),
  .mv_func  (mv_func),
  .busy     (busy),
  .mv_valid (mv_valid)
);

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [5:0]       op_func = '0;
  logic [WIDTH-1:0] opnd_a = '0;
  logic [WIDTH-1:0] opnd_b = '0;
  logic             mv_req = 1'b0;
  logic [5:0]       mv_func = '0;
  logic             busy;
  logic             mv_valid;
  logic [WIDTH-1:0] mv_data;

  int total = 0;
  int bad = 0;
  logic [31:0] m_hi = '0;
  logic [31:0] m_lo = '0;

  muldiv_unit #(.WIDTH(WIDTH)) u_muldiv_unit (
    .clk(clk), .rst(rst), .start(start), .op_func(op_func),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .mv_req(mv_req), .mv_func(mv_func),
    .busy(busy), .mv_valid(mv_valid), .mv_data(mv_data)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [5:0] f, input logic [31:0] a,
                                input logic [31:0] b);
    longint sa, sb, t;
    logic [63:0] u;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'd24: begin t = sa * sb; u = t; m_hi = u[63:32]; m_lo = u[31:0]; end
      6'd25: begin u = {32'b0, a} * {32'b0, b}; m_hi = u[63:32]; m_lo = u[31:0]; end
      6'd26: if (b != 0) begin
        t = sa / sb; u = t; m_lo = u[31:0];
        t = sa % sb; u = t; m_hi = u[31:0];
      end
      6'd27: if (b != 0) begin m_lo = a / b; m_hi = a % b; end
      default: ;
    endcase
  endfunction

  task automatic read_mv(input logic [5:0] f, input logic [31:0] exp, input string req);
    @(negedge clk);
    mv_req = 1'b1; mv_func = f;
    @(negedge clk);
    mv_req = 1'b0;
    check(mv_valid === 1'b1, {req, " valid"}, 64'(mv_valid), 64'd1);
    check(mv_data === exp, req, 64'(mv_data), 64'(exp));
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, input string req);
    int n;
    @(negedge clk);
    start = 1'b1; op_func = f; opnd_a = a; opnd_b = b;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1 busy after start", 64'(busy), 64'd1);
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (poke && n == 3) begin
        start = 1'b1; op_func = 6'd25; opnd_a = 32'h1234; opnd_b = 32'h77;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(n == 32, poke ? "R2 busy length with extra start" : "R1 busy length",
          64'(n), 64'd32);
    model(f, a, b);
    read_mv(6'd16, m_hi, {req, " Hi"});
    read_mv(6'd18, m_lo, {req, " Lo"});
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] rf;
    logic [31:0] ra, rb;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(busy === 1'b0, "R10 busy", 64'(busy), 64'd0);
    check(mv_valid === 1'b0, "R10 mv_valid", 64'(mv_valid), 64'd0);
    read_mv(6'd16, 32'd0, "R10 Hi reset");
    read_mv(6'd18, 32'd0, "R10 Lo reset");

    // R3 signed multiply corners
    run_op(6'd24, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R3 -1*-1");
    run_op(6'd24, 32'h80000000, 32'h80000000, 1'b0, "R3 min*min");
    run_op(6'd24, 32'h7FFFFFFF, 32'hFFFFFFFE, 1'b0, "R3 max*-2");
    // R4 unsigned multiply
    run_op(6'd25, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R4 ones*ones");
    run_op(6'd25, 32'h80000000, 32'h80000000, 1'b0, "R4 msb*msb");
    // R5 signed divide
    run_op(6'd26, 32'hFFFFFFF9, 32'd2, 1'b0, "R5 -7/2");
    run_op(6'd26, 32'd7, 32'hFFFFFFFE, 1'b0, "R5 7/-2");
    run_op(6'd26, 32'h80000000, 32'hFFFFFFFF, 1'b0, "R5 min/-1");
    check(m_lo == 32'h80000000 && m_hi == 0, "R5 wrap model", {m_hi, m_lo}, 64'h80000000);
    // R6 unsigned divide
    run_op(6'd27, 32'hFFFFFFFF, 32'd3, 1'b0, "R6 ones/3");
    run_op(6'd27, 32'd5, 32'd9, 1'b0, "R6 5/9");
    // R7 divide by zero keeps Hi/Lo
    run_op(6'd25, 32'hDEAD, 32'hBEEF, 1'b0, "R4 seed");
    run_op(6'd26, 32'h1234, 32'd0, 1'b0, "R7 signed div zero");
    run_op(6'd27, 32'hFFFF, 32'd0, 1'b0, "R7 unsigned div zero");

    // R2 start while busy ignored
    run_op(6'd24, 32'hFFFF0001, 32'd3, 1'b1, "R2 ignored restart");
    // R2 unknown op code ignored
    @(negedge clk);
    start = 1'b1; op_func = 6'd30; opnd_a = 32'd9; opnd_b = 32'd9;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0, "R2 bad code busy", 64'(busy), 64'd0);
    read_mv(6'd18, m_lo, "R2 bad code Lo kept");

    // R8 unknown move code
    @(negedge clk);
    mv_req = 1'b1; mv_func = 6'd17;
    @(negedge clk);
    mv_req = 1'b0;
    check(mv_valid === 1'b0, "R8 unknown move code", 64'(mv_valid), 64'd0);

    // R9 move request while busy is held
    @(negedge clk);
    start = 1'b1; op_func = 6'd27; opnd_a = 32'd100; opnd_b = 32'd7;
    @(negedge clk);
    start = 1'b0; mv_req = 1'b1; mv_func = 6'd16;
    @(negedge clk);
    mv_req = 1'b0;
    model(6'd27, 32'd100, 32'd7);
    begin
      int n = 0;
      while (busy && n < 100) begin
        n++;
        check(mv_valid === 1'b0, "R9 no answer while busy", 64'(mv_valid), 64'd0);
        @(negedge clk);
      end
    end
    check(mv_valid === 1'b0, "R9 not yet at busy fall", 64'(mv_valid), 64'd0);
    @(negedge clk);
    check(mv_valid === 1'b1, "R9 held answer valid", 64'(mv_valid), 64'd1);
    check(mv_data === m_hi, "R9 held answer data", 64'(mv_data), 64'(m_hi));

    // random mix
    for (int i = 0; i < 40; i++) begin
      rf = 6'd24 + 6'($urandom_range(0, 3));
      ra = $urandom;
      rb = ($urandom_range(0, 9) == 0) ? 32'd0 : $urandom;
      if ($urandom_range(0, 3) == 0) rb = rb >> $urandom_range(0, 31);
      case (rf)
        6'd24: run_op(rf, ra, rb, 1'b0, "R3 random");
        6'd25: run_op(rf, ra, rb, 1'b0, "R4 random");
        6'd26: run_op(rf, ra, rb, 1'b0, rb == 0 ? "R7 random" : "R5 random");
        default: run_op(rf, ra, rb, 1'b0, rb == 0 ? "R7 random" : "R6 random");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule